// File: doc/BRIEF.md
# Three-Way Interrupt Cause Controller

This block gathers hardware event pulses from three sources (transmit, receive and miscellaneous) into three 32-bit cause units. Each unit keeps a sticky cause register, a mask register written through separate set and clear addresses, and a per-bit mode register. The mode decides whether a cause bit is acknowledged by reading it or by writing a 1 to it. Software can also raise any cause bit itself through a set-cause address.

A summary register holds one bit per unit. A bit latches whenever its unit has a pending cause bit that the unit's mask leaves through. Reading the summary register clears it. The summary register has its own mask, and the single interrupt line is high while any summary bit is set and unmasked by that mask.

Registers sit on a simple single-cycle port. Writes take effect at the clock edge where the write strobe is high. Read data is valid in the same cycle as the read strobe, and any clear caused by that read happens at that cycle's edge.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset, every unit mask reads 0xFFFFFFFF, every cause and mode register reads 0, the summary mask (address 25) reads 0xFFFFFFFF, the summary register (address 24) reads 0, and `irqOut` is low.
- R2: Units are TX, RX and MISC at address bases 0, 8 and 16. Writing offset 2 sets the mask bits written as 1. Writing offset 3 clears the mask bits written as 1. Zero bits leave the mask unchanged. Offset 6 reads the mask back.
- R3: Writing offset 1 ORs the written bits into the unit's cause register (offset 0).
- R4: Cause bits whose mode bit (offset 4) is 0 are cleared by writing 1 to them at offset 0, and a read of offset 0 leaves them unchanged.
- R5: Cause bits whose mode bit is 1 are returned by a read of offset 0 and cleared by it, and writing 1 to them at offset 0 leaves them set.
- R6: Offset 5 reads the cause bits AND the inverse of the mask.
- R7: Event input bits OR into the cause register at each clock edge, and an event bit wins over a read or write clear of the same bit in the same cycle.
- R8: Summary bit 0 (TX), bit 1 (RX) or bit 2 (MISC) is set one cycle after its unit has a cause bit that is set and unmasked. It stays set until address 24 is read. The read returns the bits and clears them, except a bit whose unit is still pending.
- R9: `irqOut` is high exactly when a summary bit is set and the summary mask bit at the same position is 0. The summary mask is written as a whole at address 25.
- R10: Each mask bit is independent: MISC bit 27 can be unmasked and masked alone while every other MISC bit and the other units' masks stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 5 | Register address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid while `regRd` is high |
| evtTx | input | 32 | Transmit event bits |
| evtRx | input | 32 | Receive event bits |
| evtMisc | input | 32 | Miscellaneous event bits |
| irqOut | output | 1 | Interrupt line |

## Verification
Cause bits are driven in three ways: software set writes, single event pulses, and events that coincide with a read or write clear. This separates the sticky OR, the acknowledge path chosen by the mode bit, and the rule that a set beats a clear. Acknowledges are tried with write-1 and with read on both mode settings, so a swapped mode decode shows as a bit that stays or vanishes. The summary path is driven with a pending unmasked unit, with a pending masked unit, and with the summary mask closed and then opened. These cases tell latching, masking and read-clear apart, including the case where a read does not clear because the unit is still pending.

// File: rtl/icc_pkg.sv
package icc_pkg;
  localparam int UNIT_CNT = 3;
  localparam int STRIDE   = 8;
  localparam int OFF_W    = $clog2(STRIDE);
  localparam int ADDR_W   = $clog2((UNIT_CNT + 1) * STRIDE);
  localparam int UNIT_W   = ADDR_W - OFF_W;

  localparam logic [OFF_W-1:0] OFF_CAUSE = 3'd0;
  localparam logic [OFF_W-1:0] OFF_SET   = 3'd1;
  localparam logic [OFF_W-1:0] OFF_MSET  = 3'd2;
  localparam logic [OFF_W-1:0] OFF_MCLR  = 3'd3;
  localparam logic [OFF_W-1:0] OFF_MODE  = 3'd4;
  localparam logic [OFF_W-1:0] OFF_MVIEW = 3'd5;
  localparam logic [OFF_W-1:0] OFF_MVAL  = 3'd6;
  localparam logic [OFF_W-1:0] OFF_SUM   = 3'd0;
  localparam logic [OFF_W-1:0] OFF_SMASK = 3'd1;

  typedef struct packed {
    logic wrCause;
    logic wrSet;
    logic wrMaskSet;
    logic wrMaskClr;
    logic wrMode;
    logic rdCause;
  } unitStb_t;

  typedef struct packed {
    logic rdSum;
    logic wrSumMask;
  } sumStb_t;
endpackage

// File: rtl/icc_ctrl.sv
module icc_ctrl
  import icc_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output unitStb_t          unitStb [UNIT_CNT],
  output sumStb_t           sumStb,
  output logic [UNIT_W-1:0] selUnit,
  output logic [OFF_W-1:0]  selOff,
  output logic              selSum
);
  assign selUnit = addr[ADDR_W-1:OFF_W];
  assign selOff  = addr[OFF_W-1:0];
  assign selSum  = (selUnit == UNIT_W'(UNIT_CNT));

  always_comb begin
    for (int u = 0; u < UNIT_CNT; u++) begin
      logic hit;
      hit = (selUnit == UNIT_W'(u));
      unitStb[u].wrCause   = hit && wrEn && (selOff == OFF_CAUSE);
      unitStb[u].wrSet     = hit && wrEn && (selOff == OFF_SET);
      unitStb[u].wrMaskSet = hit && wrEn && (selOff == OFF_MSET);
      unitStb[u].wrMaskClr = hit && wrEn && (selOff == OFF_MCLR);
      unitStb[u].wrMode    = hit && wrEn && (selOff == OFF_MODE);
      unitStb[u].rdCause   = hit && rdEn && (selOff == OFF_CAUSE);
    end
    sumStb.rdSum     = selSum && rdEn && (selOff == OFF_SUM);
    sumStb.wrSumMask = selSum && wrEn && (selOff == OFF_SMASK);
  end
endmodule

// File: rtl/icc_unit.sv
module icc_unit
  import icc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  unitStb_t          stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] evt,
  output logic [DATA_W-1:0] cause,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] mode,
  output logic              pending
);
  logic [DATA_W-1:0] clrBits, causeNext, maskNext;

  always_comb begin
    clrBits = '0;
    if (stb.wrCause) clrBits = clrBits | (wdata & ~mode);
    if (stb.rdCause) clrBits = clrBits | mode;
    causeNext = (cause & ~clrBits) | evt | (stb.wrSet ? wdata : '0);
    maskNext = mask;
    if (stb.wrMaskSet) maskNext = maskNext | wdata;
    if (stb.wrMaskClr) maskNext = maskNext & ~wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cause <= '0;
      mask  <= '1;
      mode  <= '0;
    end else begin
      cause <= causeNext;
      mask  <= maskNext;
      if (stb.wrMode) mode <= wdata;
    end
  end

  assign pending = |(cause & ~mask);

  // R2: written ones end up set or cleared in the mask
  a_r2_mask_set: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrMaskSet |=> ((mask & $past(wdata)) == $past(wdata)));
  a_r2_mask_clr: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrMaskClr |=> ((mask & $past(wdata)) == '0));
  // R7: an event bit is never lost
  a_r7_event_kept: assert property (@(posedge clk) disable iff (!rstN)
    (evt != '0) |=> ((cause & $past(evt)) == $past(evt)));
  // R5: a read clears read-mode bits unless an event re-set them
  a_r5_cor_clear: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdCause |=> ((cause & $past(mode) & ~$past(evt)) == '0));
  // R4: a read leaves write-mode bits alone
  a_r4_read_keeps: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdCause |=> ((cause & $past(cause) & ~$past(mode)) == ($past(cause) & ~$past(mode))));
endmodule

// File: rtl/icc_datapath.sv
module icc_datapath
  import icc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  unitStb_t          unitStb [UNIT_CNT],
  input  sumStb_t           sumStb,
  input  logic [UNIT_W-1:0] selUnit,
  input  logic [OFF_W-1:0]  selOff,
  input  logic              selSum,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] evtVec [UNIT_CNT],
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [DATA_W-1:0]   causeQ [UNIT_CNT];
  logic [DATA_W-1:0]   maskQ  [UNIT_CNT];
  logic [DATA_W-1:0]   modeQ  [UNIT_CNT];
  logic [UNIT_CNT-1:0] pend;
  logic [UNIT_CNT-1:0] sumQ;
  logic [DATA_W-1:0]   sumMask;

  for (genvar u = 0; u < UNIT_CNT; u++) begin : g_unit
    icc_unit #(.DATA_W(DATA_W)) uUnit (
      .clk     (clk),
      .rstN    (rstN),
      .stb     (unitStb[u]),
      .wdata   (wdata),
      .evt     (evtVec[u]),
      .cause   (causeQ[u]),
      .mask    (maskQ[u]),
      .mode    (modeQ[u]),
      .pending (pend[u])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumQ    <= '0;
      sumMask <= '1;
    end else begin
      sumQ <= sumStb.rdSum ? pend : (sumQ | pend);
      if (sumStb.wrSumMask) sumMask <= wdata;
    end
  end

  assign irq = |(sumQ & ~sumMask[UNIT_CNT-1:0]);

  always_comb begin
    logic [DATA_W-1:0] selCause, selMask, selMode;
    selCause = '0;
    selMask  = '0;
    selMode  = '0;
    for (int u = 0; u < UNIT_CNT; u++) begin
      if (selUnit == UNIT_W'(u)) begin
        selCause = causeQ[u];
        selMask  = maskQ[u];
        selMode  = modeQ[u];
      end
    end
    rdata = '0;
    if (selSum) begin
      if (selOff == OFF_SUM)   rdata = DATA_W'(sumQ);
      if (selOff == OFF_SMASK) rdata = sumMask;
    end else begin
      case (selOff)
        OFF_CAUSE: rdata = selCause;
        OFF_MODE:  rdata = selMode;
        OFF_MVIEW: rdata = selCause & ~selMask;
        OFF_MVAL:  rdata = selMask;
        default:   rdata = '0;
      endcase
    end
  end

  // R8: a pending unit shows in the summary on the next cycle
  a_r8_sum_follows: assert property (@(posedge clk) disable iff (!rstN)
    (pend != '0) |=> ((sumQ & $past(pend)) == $past(pend)));
  // R8: a summary read keeps only still-pending units
  a_r8_sum_cor: assert property (@(posedge clk) disable iff (!rstN)
    sumStb.rdSum |=> ((sumQ & ~$past(pend)) == '0));
  // R9: the line needs a latched summary bit
  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (sumQ != '0));
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import icc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [DATA_W-1:0] evtTx,
  input  logic [DATA_W-1:0] evtRx,
  input  logic [DATA_W-1:0] evtMisc,
  output logic              irqOut
);
  unitStb_t          unitStb [UNIT_CNT];
  sumStb_t           sumStb;
  logic [UNIT_W-1:0] selUnit;
  logic [OFF_W-1:0]  selOff;
  logic              selSum;
  logic [DATA_W-1:0] evtVec [UNIT_CNT];

  assign evtVec[0] = evtTx;
  assign evtVec[1] = evtRx;
  assign evtVec[2] = evtMisc;

  icc_ctrl uCtrl (
    .wrEn    (regWr),
    .rdEn    (regRd),
    .addr    (regAddr),
    .unitStb (unitStb),
    .sumStb  (sumStb),
    .selUnit (selUnit),
    .selOff  (selOff),
    .selSum  (selSum)
  );

  icc_datapath #(.DATA_W(DATA_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .unitStb (unitStb),
    .sumStb  (sumStb),
    .selUnit (selUnit),
    .selOff  (selOff),
    .selSum  (selSum),
    .wdata   (regWdata),
    .evtVec  (evtVec),
    .rdata   (regRdata),
    .irq     (irqOut)
  );
endmodule

// File: tb/tb_irq_cause_ctrl.sv
module tb_irq_cause_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [31:0] evtTx = '0;
  logic [31:0] evtRx = '0;
  logic [31:0] evtMisc = '0;
  logic        irqOut;
  int checks = 0;
  int errors = 0;
  logic [31:0] v;

  localparam logic [31:0] B27 = 32'h0800_0000;

  always #4 clk = ~clk;

  irq_cause_ctrl dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .evtTx(evtTx), .evtRx(evtRx),
    .evtMisc(evtMisc), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rdReg(6, v);  chk("R1 tx mask", v, 32'hFFFF_FFFF);
    rdReg(14, v); chk("R1 rx mask", v, 32'hFFFF_FFFF);
    rdReg(22, v); chk("R1 misc mask", v, 32'hFFFF_FFFF);
    rdReg(0, v);  chk("R1 tx cause", v, 0);
    rdReg(12, v); chk("R1 rx mode", v, 0);
    rdReg(25, v); chk("R1 sum mask", v, 32'hFFFF_FFFF);
    rdReg(24, v); chk("R1 sum", v, 0);
    chk("R1 irq", {31'd0, irqOut}, 0);
  endtask

  task automatic t_mask();
    wrReg(3, 32'h3); rdReg(6, v); chk("R2 mask clear", v, 32'hFFFF_FFFC);
    wrReg(2, 32'h1); rdReg(6, v); chk("R2 mask set", v, 32'hFFFF_FFFD);
    wrReg(3, 32'h0); wrReg(2, 32'h0);
    rdReg(6, v); chk("R2 zero writes ignored", v, 32'hFFFF_FFFD);
  endtask

  task automatic t_bit27();
    wrReg(19, B27);
    rdReg(22, v); chk("R10 misc bit27 alone", v, ~B27);
    rdReg(14, v); chk("R10 rx mask untouched", v, 32'hFFFF_FFFF);
    wrReg(18, B27);
    rdReg(22, v); chk("R10 misc bit27 remasked", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_set_w1c();
    wrReg(1, 32'h2); wrReg(1, 32'h4);
    rdReg(0, v); chk("R3 set ORs", v, 32'h6);
    rdReg(5, v); chk("R6 masked view", v, 32'h2);
    rdReg(0, v); chk("R4 read keeps", v, 32'h6);
    wrReg(0, 32'h4); rdReg(0, v); chk("R4 w1c", v, 32'h2);
    wrReg(0, 32'h0); rdReg(0, v); chk("R4 zero write", v, 32'h2);
    wrReg(0, 32'h2); rdReg(0, v); chk("R4 w1c last", v, 32'h0);
  endtask

  task automatic t_cor();
    wrReg(12, 32'hFF);
    rdReg(12, v); chk("R5 mode readback", v, 32'hFF);
    @(negedge clk); evtRx = 32'h11; @(negedge clk); evtRx = '0;
    rdReg(8, v); chk("R5 cor value", v, 32'h11);
    rdReg(8, v); chk("R5 cor cleared", v, 32'h0);
    wrReg(9, 32'h101); wrReg(8, 32'h101);
    rdReg(8, v); chk("R5 w1c spares cor bit", v, 32'h1);
    rdReg(8, v); chk("R5 cor after read", v, 32'h0);
  endtask

  task automatic t_race();
    wrReg(1, 32'h8);
    @(negedge clk);
    regAddr = 0; regWdata = 32'h8; regWr = 1'b1; evtTx = 32'h8;
    @(negedge clk);
    regWr = 1'b0; evtTx = '0;
    rdReg(0, v); chk("R7 event beats w1c", v, 32'h8);
    wrReg(0, 32'h8);
    @(negedge clk); evtRx = 32'h1; @(negedge clk); evtRx = '0;
    @(negedge clk);
    regAddr = 8; regRd = 1'b1; evtRx = 32'h1;
    #1 v = regRdata;
    @(negedge clk);
    regRd = 1'b0; evtRx = '0;
    chk("R7 read value", v, 32'h1);
    rdReg(8, v); chk("R7 event beats cor", v, 32'h1);
    rdReg(8, v); chk("R7 cleared later", v, 32'h0);
  endtask

  task automatic t_summary();
    rdReg(24, v);
    rdReg(24, v); chk("R8 sum idle", v, 0);
    wrReg(25, 32'hFFFF_FFF8);
    rdReg(25, v); chk("R9 sum mask readback", v, 32'hFFFF_FFF8);
    chk("R9 irq idle", {31'd0, irqOut}, 0);
    wrReg(1, 32'h2);
    idle();
    chk("R9 irq raised", {31'd0, irqOut}, 1);
    rdReg(24, v); chk("R8 tx bit", v, 32'h1);
    rdReg(24, v); chk("R8 still pending", v, 32'h1);
    wrReg(0, 32'h2);
    rdReg(24, v); chk("R8 sticky", v, 32'h1);
    rdReg(24, v); chk("R8 cleared by read", v, 32'h0);
    chk("R9 irq dropped", {31'd0, irqOut}, 0);
    wrReg(9, 32'h4);
    idle();
    rdReg(24, v); chk("R8 masked unit ignored", v, 32'h0);
    wrReg(8, 32'h4);
    rdReg(8, v); chk("R5 write spares cor bit", v, 32'h4);
  endtask

  task automatic t_summask();
    wrReg(25, 32'hFFFF_FFFF);
    wrReg(19, B27); wrReg(17, B27);
    idle();
    chk("R9 blocked by sum mask", {31'd0, irqOut}, 0);
    rdReg(21, v); chk("R6 misc view", v, B27);
    wrReg(25, 32'hFFFF_FFFB);
    chk("R9 opened", {31'd0, irqOut}, 1);
    rdReg(24, v); chk("R8 misc bit", v, 32'h4);
    wrReg(16, B27);
    rdReg(24, v); chk("R8 misc sticky", v, 32'h4);
    rdReg(24, v); chk("R8 misc cleared", v, 32'h0);
    chk("R9 misc irq off", {31'd0, irqOut}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_mask();
    t_bit27();
    t_set_w1c();
    t_cor();
    t_race();
    t_summary();
    t_summask();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule